// File: doc/BRIEF.md
# Exception Entry Dispatch Sequencer

This block runs the hardware side of taking an exception on a 64-bit core. The pipeline raises a request with an 8-bit vector and the instruction pointer and flags word that must be preserved. The sequencer writes both to the stack. It then fetches the 16-byte gate record for that vector from the descriptor table, reading it as four 32-bit words. It checks that the record is usable, works out the entry flags, and presents the handler target: a code-segment selector, a 64-bit handler address and a stack-switch index.

When the record is unusable, the sequencer escalates. This covers a missing record, a malformed record, a read that returns an error, and a fault reported by the pipeline while the sequence is running. On the first escalation the whole sequence starts again on the double-fault vector (8), and the block records that it is now at double-fault nesting. A second escalation at that nesting level cannot be dispatched. The block then pulses a processor reset for one cycle and returns to idle with the nesting cleared. The pipeline signals the end of a handler with a done strobe, which clears the nesting level while the sequencer is idle.

States: IDLE (wait for a request), PUSH_IP and PUSH_FL (two stack writes), RD_ISSUE and RD_WAIT (one read per descriptor word, four times), CHECK (validate), DISPATCH (present the target), ESCALATE (choose between double fault and triple fault), TRIPLE (reset pulse). Transitions:
- IDLE→PUSH_IP on a request.
- PUSH_IP→PUSH_FL→RD_ISSUE.
- RD_ISSUE→RD_WAIT.
- RD_WAIT→RD_ISSUE after a word that is not the last.
- RD_WAIT→CHECK after the last word.
- CHECK→DISPATCH→IDLE.
- From any working state to ESCALATE on a fault, an error response or a failed check.
- ESCALATE→PUSH_IP at nesting 0.
- ESCALATE→TRIPLE at nesting 1.
- TRIPLE→IDLE.

Top module: `exc_entry_seq`

## Requirements
- R1: After a request is accepted, the stack port writes exactly two consecutive words: the saved instruction pointer first, then the 16-bit flags word zero-extended to 64 bits.
- R2: The gate record is read as four single 32-bit reads, with no more than one read outstanding. Read k (k = 0..3) goes to address table_base + 16*vector + 4*k, in increasing order of k.
- R3: The handler address is {word2[31:0], word1[31:16], word0[15:0]}. The selector is word0[31:16]. The stack-switch index is word1[2:0]. The privilege field is word1[14:13].
- R4: The option word is word1[15:0]. A record is usable only if option bit 15 is 1, option bits 11..9 are all 1 and option bit 12 is 0. Any other record is treated as absent.
- R5: Option bit 8 = 0 (interrupt gate) yields entry flags equal to the saved flags with bit 9 (mask 0x0200) cleared. Option bit 8 = 1 (trap gate) yields the saved flags unchanged.
- R6: At nesting level 0, an escalation cause starts the sequence again on vector 8 and sets the nesting level to 1. The sequence restarts with both stack writes. The causes are an absent record, an error response on any read, and the fault input while pushing, reading or checking.
- R7: An escalation at nesting level 1 dispatches nothing. It raises the reset output for exactly one cycle, clears the nesting level and returns to idle.
- R8: The handler-done input, seen while idle, clears the nesting level. A later absent record then yields a double-fault dispatch rather than a reset.
- R9: Each successful sequence raises the dispatch strobe for exactly one cycle, together with the vector actually dispatched and its target fields.
- R10: Out of reset, every strobe (acknowledge, stack write, read request, dispatch, reset pulse) is low and the nesting level is 0.
- R11: The acknowledge output is high only in an idle cycle in which a request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception request |
| exc_vec | input | 8 | Vector of the request |
| exc_ack | output | 1 | Request taken this cycle |
| cur_ip | input | 64 | Instruction pointer to save |
| cur_flags | input | 16 | Flags word to save |
| inv_fault | input | 1 | Fault raised during entry |
| handler_done | input | 1 | Handler finished; clears nesting |
| tbl_base | input | 64 | Descriptor table base address |
| stk_wr_en | output | 1 | Stack write strobe |
| stk_wr_data | output | 64 | Stack write data |
| rd_req | output | 1 | Table read request |
| rd_addr | output | 64 | Table read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response error |
| ent_valid | output | 1 | Dispatch strobe |
| ent_vec | output | 8 | Dispatched vector |
| ent_sel | output | 16 | New code-segment selector |
| ent_ip | output | 64 | Handler address |
| ent_ist | output | 3 | Stack-switch index |
| ent_dpl | output | 2 | Gate privilege field |
| ent_flags | output | 16 | Flags on entry |
| cpu_reset | output | 1 | Triple-fault reset pulse |

## Verification
Random vectors with random gate records exercise assembly and the choice between interrupt gate and trap gate. A wrong half-word ordering shows up in the handler address, and a wrong gate-bit test shows up in the flags. Directed cases separate the three escalation causes: an absent or malformed record, an error response on a middle word, and a pipeline fault during the reads. Each must produce the double-fault restart with four stack writes. Back-to-back escalations without a done strobe must end in the reset pulse, while the same pattern with a done strobe in between must not. This separates correct nesting bookkeeping from a level that never sets or never clears. A double-fault record that is itself absent forces a triple fault from a single request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_IP,
        ST_PUSH_FL,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_CHECK,
        ST_DISPATCH,
        ST_ESCALATE,
        ST_TRIPLE
    } seq_state_e;

    localparam int unsigned OPT_PRESENT_BIT = 15;
    localparam int unsigned OPT_MBZ_BIT     = 12;
    localparam int unsigned OPT_MBO_HI      = 11;
    localparam int unsigned OPT_MBO_LO      = 9;
    localparam int unsigned OPT_GATE_BIT    = 8;
    localparam int unsigned FLAG_IE_BIT     = 9;

endpackage

// File: rtl/exc_desc_store.sv
module exc_desc_store #(
    parameter int DATA_W     = 32,
    parameter int KEEP_WORDS = 3,
    parameter int IDX_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [KEEP_WORDS*DATA_W-1:0] words
);

    for (genvar g = 0; g < KEEP_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                word_q <= wr_data;
            end
        end

        assign words[g*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/exc_desc_decode.sv
module exc_desc_decode
    import exc_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IP_W   = 64
) (
    input  logic [3*DATA_W-1:0] words,
    output logic                usable,
    output logic                trap_gate,
    output logic [15:0]         sel,
    output logic [IP_W-1:0]     hip,
    output logic [2:0]          ist,
    output logic [1:0]          dpl
);

    logic [DATA_W-1:0] w0, w1, w2;
    logic [15:0]       opt;

    always_comb begin
        w0  = words[0*DATA_W +: DATA_W];
        w1  = words[1*DATA_W +: DATA_W];
        w2  = words[2*DATA_W +: DATA_W];
        opt = w1[15:0];

        sel       = w0[31:16];
        hip       = {w2, w1[31:16], w0[15:0]};
        ist       = opt[2:0];
        dpl       = opt[14:13];
        trap_gate = opt[OPT_GATE_BIT];
        usable    = opt[OPT_PRESENT_BIT]
                  & (&opt[OPT_MBO_HI:OPT_MBO_LO])
                  & ~opt[OPT_MBZ_BIT];
    end

endmodule

// File: rtl/exc_nest_track.sv
module exc_nest_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_df,
    input  logic clear,
    output logic in_df
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_df <= 1'b0;
        end else if (clear) begin
            in_df <= 1'b0;
        end else if (set_df) begin
            in_df <= 1'b1;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int          VEC_W      = 8,
    parameter int          IP_W       = 64,
    parameter int          FLAG_W     = 16,
    parameter int          DATA_W     = 32,
    parameter int          DESC_WORDS = 4,
    parameter logic [7:0]  DF_VEC     = 8'd8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [VEC_W-1:0]  exc_vec,
    output logic              exc_ack,
    input  logic [IP_W-1:0]   cur_ip,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic              inv_fault,
    input  logic              handler_done,
    input  logic [IP_W-1:0]   tbl_base,
    output logic              stk_wr_en,
    output logic [IP_W-1:0]   stk_wr_data,
    output logic              rd_req,
    output logic [IP_W-1:0]   rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              ent_valid,
    output logic [VEC_W-1:0]  ent_vec,
    output logic [15:0]       ent_sel,
    output logic [IP_W-1:0]   ent_ip,
    output logic [2:0]        ent_ist,
    output logic [1:0]        ent_dpl,
    output logic [FLAG_W-1:0] ent_flags,
    output logic              cpu_reset
);

    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int KEEP_WORDS = 3;
    localparam int DESC_SHIFT = $clog2(DESC_WORDS * DATA_W / 8);
    localparam int WORD_SHIFT = $clog2(DATA_W / 8);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    seq_state_e state_q, state_d;

    logic [VEC_W-1:0]  vec_q;
    logic [IP_W-1:0]   sv_ip_q;
    logic [FLAG_W-1:0] sv_fl_q;
    logic [IDX_W-1:0]  widx_q;

    logic [KEEP_WORDS*DATA_W-1:0] desc_words;
    logic              dec_ok, dec_trap;
    logic [15:0]       dec_sel;
    logic [IP_W-1:0]   dec_ip;
    logic [2:0]        dec_ist;
    logic [1:0]        dec_dpl;
    logic              in_df;
    logic              fault_now;
    logic              word_take;

    always_comb begin
        unique case (state_q)
            ST_PUSH_IP, ST_PUSH_FL, ST_RD_ISSUE, ST_RD_WAIT, ST_CHECK:
                fault_now = inv_fault;
            default:
                fault_now = 1'b0;
        endcase
    end

    assign word_take = (state_q == ST_RD_WAIT) && rd_valid && !rd_err && !fault_now;

    exc_desc_store #(
        .DATA_W     (DATA_W),
        .KEEP_WORDS (KEEP_WORDS),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (word_take),
        .wr_idx  (widx_q),
        .wr_data (rd_data),
        .words   (desc_words)
    );

    exc_desc_decode #(
        .DATA_W (DATA_W),
        .IP_W   (IP_W)
    ) u_dec (
        .words     (desc_words),
        .usable    (dec_ok),
        .trap_gate (dec_trap),
        .sel       (dec_sel),
        .hip       (dec_ip),
        .ist       (dec_ist),
        .dpl       (dec_dpl)
    );

    exc_nest_track u_nest (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_df ((state_q == ST_ESCALATE) && !in_df),
        .clear  ((state_q == ST_TRIPLE) || ((state_q == ST_IDLE) && handler_done)),
        .in_df  (in_df)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (exc_req) state_d = ST_PUSH_IP;
            ST_PUSH_IP:  state_d = fault_now ? ST_ESCALATE : ST_PUSH_FL;
            ST_PUSH_FL:  state_d = fault_now ? ST_ESCALATE : ST_RD_ISSUE;
            ST_RD_ISSUE: state_d = fault_now ? ST_ESCALATE : ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (fault_now) begin
                    state_d = ST_ESCALATE;
                end else if (rd_valid) begin
                    if (rd_err)                  state_d = ST_ESCALATE;
                    else if (widx_q == LAST_IDX) state_d = ST_CHECK;
                    else                         state_d = ST_RD_ISSUE;
                end
            end
            ST_CHECK:    state_d = (fault_now || !dec_ok) ? ST_ESCALATE : ST_DISPATCH;
            ST_DISPATCH: state_d = ST_IDLE;
            ST_ESCALATE: state_d = in_df ? ST_TRIPLE : ST_PUSH_IP;
            ST_TRIPLE:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            sv_ip_q <= '0;
            sv_fl_q <= '0;
            widx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && exc_req) begin
                vec_q   <= exc_vec;
                sv_ip_q <= cur_ip;
                sv_fl_q <= cur_flags;
            end
            if (state_q == ST_ESCALATE && !in_df) begin
                vec_q <= DF_VEC;
            end
            if (state_q == ST_PUSH_FL) begin
                widx_q <= '0;
            end else if (word_take && widx_q != LAST_IDX) begin
                widx_q <= widx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        exc_ack     = 1'b0;
        stk_wr_en   = 1'b0;
        stk_wr_data = '0;
        rd_req      = 1'b0;
        rd_addr     = tbl_base + (IP_W'(vec_q) << DESC_SHIFT) + (IP_W'(widx_q) << WORD_SHIFT);
        ent_valid   = 1'b0;
        ent_vec     = vec_q;
        ent_sel     = dec_sel;
        ent_ip      = dec_ip;
        ent_ist     = dec_ist;
        ent_dpl     = dec_dpl;
        ent_flags   = dec_trap ? sv_fl_q : (sv_fl_q & ~(FLAG_W'(1) << FLAG_IE_BIT));
        cpu_reset   = 1'b0;
        unique case (state_q)
            ST_IDLE:     exc_ack = exc_req;
            ST_PUSH_IP: begin
                stk_wr_en   = 1'b1;
                stk_wr_data = sv_ip_q;
            end
            ST_PUSH_FL: begin
                stk_wr_en   = 1'b1;
                stk_wr_data = IP_W'(sv_fl_q);
            end
            ST_RD_ISSUE: rd_req    = 1'b1;
            ST_DISPATCH: ent_valid = 1'b1;
            ST_TRIPLE:   cpu_reset = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req,
    input logic        exc_ack,
    input logic        stk_wr_en,
    input logic        rd_req,
    input logic        ent_valid,
    input logic        cpu_reset,
    input logic [15:0] ent_flags,
    input logic        trap_gate,
    input logic        desc_ok
);

    // R1
    push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_wr_en) |=> stk_wr_en);

    // R1
    push_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_wr_en && $past(stk_wr_en)) |=> !stk_wr_en);

    // R2
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4
    usable_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> desc_ok);

    // R5
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && !trap_gate) |-> !ent_flags[9]);

    // R7
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |=> (!cpu_reset && !ent_valid));

    // R9
    ent_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> !ent_valid);

    // R11
    ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ack |-> exc_req);

endmodule

bind exc_entry_seq exc_entry_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_req   (exc_req),
    .exc_ack   (exc_ack),
    .stk_wr_en (stk_wr_en),
    .rd_req    (rd_req),
    .ent_valid (ent_valid),
    .cpu_reset (cpu_reset),
    .ent_flags (ent_flags),
    .trap_gate (dec_trap),
    .desc_ok   (dec_ok)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

    localparam logic [63:0] BASE = 64'h0000_0000_0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [7:0]  exc_vec = '0;
    logic        exc_ack;
    logic [63:0] cur_ip = '0;
    logic [15:0] cur_flags = '0;
    logic        inv_fault = 1'b0;
    logic        handler_done = 1'b0;
    logic        stk_wr_en;
    logic [63:0] stk_wr_data;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        rd_err = 1'b0;
    logic        ent_valid;
    logic [7:0]  ent_vec;
    logic [15:0] ent_sel;
    logic [63:0] ent_ip;
    logic [2:0]  ent_ist;
    logic [1:0]  ent_dpl;
    logic [15:0] ent_flags;
    logic        cpu_reset;

    always #10 clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec), .exc_ack(exc_ack),
        .cur_ip(cur_ip), .cur_flags(cur_flags), .inv_fault(inv_fault),
        .handler_done(handler_done), .tbl_base(BASE), .stk_wr_en(stk_wr_en),
        .stk_wr_data(stk_wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_err(rd_err), .ent_valid(ent_valid), .ent_vec(ent_vec),
        .ent_sel(ent_sel), .ent_ip(ent_ip), .ent_ist(ent_ist), .ent_dpl(ent_dpl),
        .ent_flags(ent_flags), .cpu_reset(cpu_reset)
    );

    logic [31:0] mem [0:127];
    int err_idx = -1;
    int fault_at = -1;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit nest_m = 0;

    // table memory: one-cycle read latency
    always @(posedge clk) begin
        int ridx;
        ridx = int'((rd_addr - BASE) >> 2) & 127;
        rd_valid <= rd_req;
        rd_data  <= mem[ridx];
        rd_err   <= rd_req && (ridx == err_idx);
    end

    // monitor
    logic [63:0] pushes [0:7];
    logic [63:0] reads  [0:15];
    int npush, nrd, n_ent, n_rst;
    logic [7:0]  m_vec;
    logic [15:0] m_sel, m_fl;
    logic [63:0] m_ip;
    logic [2:0]  m_ist;
    logic [1:0]  m_dpl;

    always @(negedge clk) begin
        inv_fault = 1'b0;
        if (stk_wr_en && npush < 8) begin
            pushes[npush] = stk_wr_data;
            npush++;
        end
        if (rd_req && nrd < 16) begin
            reads[nrd] = rd_addr;
            if (fault_at == nrd) begin
                inv_fault = 1'b1;
                fault_at  = -1;
            end
            nrd++;
        end
        if (ent_valid) begin
            n_ent++;
            m_vec = ent_vec; m_sel = ent_sel; m_ip = ent_ip;
            m_ist = ent_ist; m_dpl = ent_dpl; m_fl = ent_flags;
        end
        if (cpu_reset) n_rst++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void put_desc(input int v, input bit present, input bit trap,
                                     input bit mbz_bad, input bit mbo_bad);
        logic [63:0] hip;
        logic [15:0] sel, opt;
        logic [2:0]  ist;
        logic [1:0]  dpl;
        hip = {$urandom, $urandom};
        sel = 16'($urandom);
        ist = 3'($urandom);
        dpl = 2'($urandom);
        opt = {present, dpl, mbz_bad, (mbo_bad ? 3'b101 : 3'b111), trap, 5'b0, ist};
        mem[v*4+0] = {sel, hip[15:0]};
        mem[v*4+1] = {hip[31:16], opt};
        mem[v*4+2] = hip[63:32];
        mem[v*4+3] = $urandom;
    endfunction

    function automatic bit rec_ok(input int v);
        logic [15:0] opt;
        opt = mem[v*4+1][15:0];
        return opt[15] && (opt[11:9] == 3'b111) && !opt[12]
               && !(err_idx >= v*4 && err_idx < v*4+4);
    endfunction

    task automatic clear_nest();
        @(negedge clk);
        handler_done = 1'b1;
        @(negedge clk);
        handler_done = 1'b0;
        nest_m = 0;
    endtask

    // run one request and compare with the model
    task automatic run_exc(input string req, input logic [7:0] v, input logic [63:0] ip,
                           input logic [15:0] fl, input bit fault_first);
        int kind, exp_push, attempts, dv;
        bit done;
        logic [31:0] w0, w1, w2;
        logic [15:0] exp_fl;
        kind = 0; exp_push = 0; attempts = 0; dv = v; done = 0;
        for (int a = 0; a < 3 && !done; a++) begin
            exp_push += 2;
            attempts++;
            if (!((a == 0 && fault_first) || !rec_ok(dv))) begin
                kind = 1; done = 1;
            end else if (nest_m) begin
                kind = 2; nest_m = 0; done = 1;
            end else begin
                nest_m = 1; dv = 8;
            end
        end

        @(negedge clk);
        npush = 0; nrd = 0; n_ent = 0; n_rst = 0;
        exc_req = 1'b1; exc_vec = v; cur_ip = ip; cur_flags = fl;
        #1;
        chk(exc_ack == 1'b1, "R11", "ack on accept", 64'(exc_ack), 64'd1);
        @(negedge clk);
        exc_req = 1'b0;
        for (int i = 0; i < 300 && n_ent == 0 && n_rst == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);

        chk(npush == exp_push, "R1", "push count", 64'(npush), 64'(exp_push));
        chk(pushes[0] == ip, "R1", "pushed ip", pushes[0], ip);
        chk(pushes[1] == {48'd0, fl}, "R1", "pushed flags", pushes[1], {48'd0, fl});
        if (!fault_first && err_idx < 0) begin
            chk(nrd == 4 * attempts, "R2", "read count", 64'(nrd), 64'(4 * attempts));
            for (int k = 0; k < 4; k++)
                chk(reads[k] == BASE + 64'(v) * 16 + 64'(k) * 4, "R2", "read address",
                    reads[k], BASE + 64'(v) * 16 + 64'(k) * 4);
        end
        if (kind == 1) begin
            w0 = mem[dv*4+0]; w1 = mem[dv*4+1]; w2 = mem[dv*4+2];
            exp_fl = w1[8] ? fl : (fl & 16'hFDFF);
            chk(n_ent == 1 && n_rst == 0, "R9", "single dispatch", 64'(n_ent), 64'd1);
            chk(m_vec == 8'(dv), (dv == 8 && v != 8) ? "R6" : "R9", "dispatched vector",
                64'(m_vec), 64'(dv));
            chk(m_ip == {w2, w1[31:16], w0[15:0]}, "R3", "handler address", m_ip,
                {w2, w1[31:16], w0[15:0]});
            chk(m_sel == w0[31:16] && m_ist == w1[2:0] && m_dpl == w1[14:13], "R3",
                "selector/index/privilege", {m_sel, 11'd0, m_ist, m_dpl},
                {w0[31:16], 11'd0, w1[2:0], w1[14:13]});
            chk(m_fl == exp_fl, "R5", "entry flags", 64'(m_fl), 64'(exp_fl));
        end else begin
            chk(n_rst == 1 && n_ent == 0, "R7", "triple-fault reset pulse",
                64'(n_rst), 64'd1);
        end
        chk(exc_ack == 1'b0 && stk_wr_en == 1'b0 && rd_req == 1'b0, "R7",
            "idle after sequence", {61'd0, exc_ack, stk_wr_en, rd_req}, 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int v = 0; v < 32; v++) put_desc(v, 1'b1, v[0], 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk({exc_ack, stk_wr_en, rd_req, ent_valid, cpu_reset} == 5'b0, "R10",
            "strobes in reset", 64'({exc_ack, stk_wr_en, rd_req, ent_valid, cpu_reset}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({exc_ack, stk_wr_en, rd_req, ent_valid, cpu_reset} == 5'b0, "R10",
            "strobes after reset", 64'({exc_ack, stk_wr_en, rd_req, ent_valid, cpu_reset}), 64'd0);

        // directed: invalid opcode vector, interrupt gate, IE set
        put_desc(6, 1'b1, 1'b0, 1'b0, 1'b0);
        run_exc("R5", 8'd6, 64'hDEAD_BEEF_0123_4567, 16'h0246, 1'b0);
        // page fault vector, trap gate, IE set
        put_desc(14, 1'b1, 1'b1, 1'b0, 1'b0);
        run_exc("R5", 8'd14, 64'h0000_7FFF_1234_0000, 16'h0202, 1'b0);

        // random mix
        for (int n = 0; n < 24; n++) begin
            int v;
            v = int'($urandom % 32);
            put_desc(v, ($urandom % 4) != 0, 1'($urandom), 1'b0, 1'b0);
            if (($urandom % 3) == 0) put_desc(8, 1'b1, 1'($urandom), 1'b0, 1'b0);
            run_exc("R3", 8'(v), {$urandom, $urandom}, 16'($urandom), 1'b0);
            if (($urandom % 2) == 0) clear_nest();
        end
        for (int v = 0; v < 32; v++) put_desc(v, 1'b1, v[0], 1'b0, 1'b0);
        clear_nest();

        // R6: absent record at nesting 0 -> double fault
        put_desc(3, 1'b0, 1'b0, 1'b0, 1'b0);
        run_exc("R6", 8'd3, 64'h1111, 16'h0200, 1'b0);
        // R7: again without done -> reset
        run_exc("R7", 8'd3, 64'h2222, 16'h0200, 1'b0);
        // R7: nesting cleared by reset pulse -> double fault again
        run_exc("R7", 8'd3, 64'h3333, 16'h0200, 1'b0);
        // R8: done clears nesting -> double fault, not reset
        clear_nest();
        run_exc("R8", 8'd3, 64'h4444, 16'h0000, 1'b0);
        chk(n_rst == 0, "R8", "no reset after done", 64'(n_rst), 64'd0);

        // R4: must-be-zero bit set
        clear_nest();
        put_desc(20, 1'b1, 1'b1, 1'b1, 1'b0);
        run_exc("R4", 8'd20, 64'h5555, 16'h0200, 1'b0);
        chk(m_vec == 8'd8, "R4", "bad reserved-zero escalates", 64'(m_vec), 64'd8);
        // R4: must-be-one bits wrong
        clear_nest();
        put_desc(21, 1'b1, 1'b1, 1'b0, 1'b1);
        run_exc("R4", 8'd21, 64'h6666, 16'h0200, 1'b0);
        chk(m_vec == 8'd8, "R4", "bad reserved-one escalates", 64'(m_vec), 64'd8);

        // R6: error response on word 2
        clear_nest();
        err_idx = 5 * 4 + 2;
        run_exc("R6", 8'd5, 64'h7777, 16'h0200, 1'b0);
        chk(m_vec == 8'd8 && n_ent == 1, "R6", "read error escalates", 64'(m_vec), 64'd8);
        err_idx = -1;

        // R6: pipeline fault during read 1
        clear_nest();
        fault_at = 1;
        run_exc("R6", 8'd9, 64'h8888, 16'h0200, 1'b1);
        chk(m_vec == 8'd8 && n_ent == 1, "R6", "fault during fetch escalates", 64'(m_vec), 64'd8);

        // R7: double-fault record itself absent -> reset from one request
        clear_nest();
        put_desc(8, 1'b0, 1'b0, 1'b0, 1'b0);
        run_exc("R7", 8'd3, 64'h9999, 16'h0200, 1'b0);
        chk(n_rst == 1, "R7", "nested absent records reset", 64'(n_rst), 64'd1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule